// File: doc/BRIEF.md
# Wear-Levelled Halfword State Store

This controller keeps the latest 16-bit state word in a single erase-before-write page of 32 halfword slots. It does not rewrite one fixed location. Each new value goes into the lowest slot that is still erased, so the page fills up as an append-only log. The page is erased only when no free slot is left. A read walks the page from the top slot downward and returns the newest programmed entry. An init request erases the page only when every slot already reads as erased. Each erase and each program is checked by reading the cells back.

The storage is modelled as flash. An erase sets every cell to one. A program can only clear bits, because the new word is ANDed with the old content. The `stuck_zero_i` mask models worn cells that can no longer hold a one. The mask applies to both erase and program, so the error paths can be exercised. Each request takes one cycle per slot scanned. `busy_o` covers the whole operation, and a one-cycle `done_o` pulse marks the point where `status_o` and `rd_data_o` become valid.

Top module: `hw_log_store`

## Requirements
- R1: After reset, busy_o and done_o are low, status_o is 0 (OK), rd_data_o is 0xFFFF, and every slot reads 0xFFFF.
- R2: A request that arrives while the block is idle raises busy_o on the next cycle. Init has priority over write, and write has priority over read. Any request that arrives while busy_o is high is ignored.
- R3: Each operation ends with a single-cycle done_o pulse, during which busy_o is low. status_o holds its value while busy_o stays high. The status codes are 0 = OK, 1 = write error (reserved), 2 = erase error and 3 = verify error.
- R4: A write scans upward from slot 0 and programs the first slot that reads 0xFFFF.
- R5: When no slot reads 0xFFFF, a write first erases the whole page and then programs slot 0.
- R6: A read scans downward from slot 31 and returns the first entry that is not 0xFFFF, or 0xFFFF if the page is empty. rd_data_o changes only when done_o is high.
- R7: Writing 0xFFFF ends with OK. The slot stays free, so a later read skips it and the next write reuses it.
- R8: After programming, the slot is read back. If it does not equal the requested value, the operation ends with status 3.
- R9: After an erase, every slot is read back. If any slot is not 0xFFFF, the operation ends with status 2 and nothing is programmed.
- R10: Init erases the page, with the check of R9, only when every slot reads 0xFFFF. Otherwise it returns OK and leaves the page unchanged.
- R11: A program stores old AND data AND NOT stuck_zero_i. An erase stores NOT stuck_zero_i in every slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_req_i | input | 1 | Append wr_data_i to the log |
| wr_data_i | input | 16 | Value to store |
| rd_req_i | input | 1 | Fetch the newest stored value |
| init_req_i | input | 1 | Conditional page erase |
| stuck_zero_i | input | 16 | Cell bits forced to zero on erase and program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| status_o | output | 2 | Result code of the last operation |
| rd_data_o | output | 16 | Result of the last read |

## Verification
The bench stores two distinct values one after another. Reading back the second value shows that the write appended to a new slot, and the read found the top entry.

Writing 0xFFFF between ordinary values shows that an erased-looking slot is skipped by reads and reused by writes. Filling all 32 slots and then writing once more tells a page erase apart from a simple overwrite, because afterwards only the newest value can be found.

Setting stuck bits before a write to a free slot separates verify errors from erase errors. Setting them before a write to a full page, or before an init on an empty page, shows the erase check at work. An init on a page that holds data must leave the stored value readable.

// File: rtl/hls_pkg.sv
package hls_pkg;
  typedef enum logic [1:0] {
    ST_OK         = 2'd0,
    ST_WR_ERR     = 2'd1,
    ST_ERASE_ERR  = 2'd2,
    ST_VERIFY_ERR = 2'd3
  } status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WSCAN, S_ERASE, S_ECHK, S_PROG, S_PCHK, S_RSCAN, S_ISCAN
  } state_e;

  typedef enum logic [1:0] {
    OP_WRITE, OP_READ, OP_INIT
  } op_e;
endpackage

// File: rtl/hls_array.sv
module hls_array #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_i,
  input  logic          prog_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  stuck_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[g] <= '1;
      else if (erase_i)                          mem_q[g] <= ~stuck_i;
      else if (prog_i && addr_i == AW'(g))       mem_q[g] <= mem_q[g] & wdata_i & ~stuck_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/hls_ctrl.sv
module hls_ctrl
  import hls_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          rd_req_i,
  input  logic          init_req_i,
  input  logic [W-1:0]  rdata_i,
  output logic          erase_o,
  output logic          prog_o,
  output logic [AW-1:0] addr_o,
  output logic [W-1:0]  wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    status_o,
  output logic [W-1:0]  rd_data_o
);
  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);
  localparam logic [W-1:0]  ERASED = '1;

  state_e        state_q;
  op_e           op_q;
  status_e       status_q;
  logic [AW-1:0] idx_q;
  logic [W-1:0]  data_q, rd_q;
  logic          done_q;
  logic          free, at_last;

  assign free    = (rdata_i == ERASED);
  assign at_last = (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      op_q     <= OP_READ;
      status_q <= ST_OK;
      idx_q    <= '0;
      data_q   <= '0;
      rd_q     <= ERASED;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (init_req_i) begin
            op_q <= OP_INIT; idx_q <= '0; state_q <= S_ISCAN;
          end else if (wr_req_i) begin
            op_q <= OP_WRITE; data_q <= wr_data_i; idx_q <= '0; state_q <= S_WSCAN;
          end else if (rd_req_i) begin
            op_q <= OP_READ; idx_q <= LAST; state_q <= S_RSCAN;
          end
        end
        S_WSCAN: begin
          if (free)         state_q <= S_PROG;
          else if (at_last) state_q <= S_ERASE;
          else              idx_q   <= idx_q + AW'(1);
        end
        S_ISCAN: begin
          if (!free) begin
            status_q <= ST_OK; done_q <= 1'b1; state_q <= S_IDLE;
          end else if (at_last) state_q <= S_ERASE;
          else                  idx_q   <= idx_q + AW'(1);
        end
        S_ERASE: begin
          idx_q <= '0; state_q <= S_ECHK;
        end
        S_ECHK: begin
          if (!free) begin
            status_q <= ST_ERASE_ERR; done_q <= 1'b1; state_q <= S_IDLE;
          end else if (at_last) begin
            if (op_q == OP_WRITE) begin
              idx_q <= '0; state_q <= S_PROG;
            end else begin
              status_q <= ST_OK; done_q <= 1'b1; state_q <= S_IDLE;
            end
          end else idx_q <= idx_q + AW'(1);
        end
        S_PROG: state_q <= S_PCHK;
        S_PCHK: begin
          status_q <= (rdata_i == data_q) ? ST_OK : ST_VERIFY_ERR;
          done_q   <= 1'b1;
          state_q  <= S_IDLE;
        end
        S_RSCAN: begin
          if (!free || idx_q == '0) begin
            rd_q <= rdata_i; status_q <= ST_OK; done_q <= 1'b1; state_q <= S_IDLE;
          end else idx_q <= idx_q - AW'(1);
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign erase_o   = (state_q == S_ERASE);
  assign prog_o    = (state_q == S_PROG);
  assign addr_o    = idx_q;
  assign wdata_o   = data_q;
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign status_o  = status_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/hw_log_store.sv
module hw_log_store #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_req_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_req_i,
  input  logic         init_req_i,
  input  logic [W-1:0] stuck_zero_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [1:0]   status_o,
  output logic [W-1:0] rd_data_o
);
  localparam int AW = $clog2(DEPTH);

  logic          erase, prog;
  logic [AW-1:0] addr;
  logic [W-1:0]  wdata, rdata;

  hls_ctrl #(.W(W), .DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .wr_req_i, .wr_data_i, .rd_req_i, .init_req_i,
    .rdata_i(rdata), .erase_o(erase), .prog_o(prog), .addr_o(addr),
    .wdata_o(wdata), .busy_o, .done_o, .status_o, .rd_data_o
  );

  hls_array #(.W(W), .DEPTH(DEPTH)) u_array (
    .clk_i, .rst_ni, .erase_i(erase), .prog_i(prog), .addr_i(addr),
    .wdata_i(wdata), .stuck_i(stuck_zero_i), .rdata_o(rdata)
  );
endmodule

// File: rtl/hls_chk.sv
module hls_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_req_i,
  input logic         rd_req_i,
  input logic         init_req_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [1:0]   status_o,
  input logic [W-1:0] rd_data_o
);
  AST_REQ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (wr_req_i || rd_req_i || init_req_i)) |=> busy_o); // R2

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R3

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3

  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(status_o)); // R3

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rd_data_o)); // R6
endmodule

bind hw_log_store hls_chk #(.W(W)) u_chk (
  .clk_i, .rst_ni, .wr_req_i, .rd_req_i, .init_req_i,
  .busy_o, .done_o, .status_o, .rd_data_o
);

// File: tb/sim_hw_log_store.sv
`timescale 1ns/1ps
module sim_hw_log_store;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_req = 1'b0, rd_req = 1'b0, init_req = 1'b0;
  logic [15:0] wr_data = '0, stuck = '0;
  logic        busy, done;
  logic [1:0]  status;
  logic [15:0] rd_data;

  int checks = 0, errors = 0;
  logic [1:0]  st_r;
  logic [15:0] rd_r;

  always #10 clk = ~clk;

  hw_log_store u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_req_i(wr_req), .wr_data_i(wr_data),
    .rd_req_i(rd_req), .init_req_i(init_req), .stuck_zero_i(stuck),
    .busy_o(busy), .done_o(done), .status_o(status), .rd_data_o(rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    if (!done) check(1'b0, "watchdog-op", 0, 1);
    st_r = status; rd_r = rd_data;
    @(negedge clk);
  endtask

  // kind: 0 write, 1 read, 2 init
  task automatic op(input int kind, input logic [15:0] d);
    @(negedge clk);
    wr_req = (kind == 0); rd_req = (kind == 1); init_req = (kind == 2); wr_data = d;
    @(negedge clk);
    wr_req = 0; rd_req = 0; init_req = 0;
    wait_done();
  endtask

  task automatic t_reset();
    check(!busy && !done, "R1 idle", {busy, done}, 0);
    check(status == 2'd0, "R1 status", status, 0);
    check(rd_data == 16'hFFFF, "R1 rd_data", rd_data, 16'hFFFF);
    op(1, 0);
    check(st_r == 0 && rd_r == 16'hFFFF, "R1 R6 empty read", rd_r, 16'hFFFF);
  endtask

  task automatic t_append();
    op(0, 16'h1111); check(st_r == 0, "R4 write status", st_r, 0);
    op(0, 16'h2222); check(st_r == 0, "R4 write status", st_r, 0);
    op(1, 0);        check(rd_r == 16'h2222, "R4 R6 newest", rd_r, 16'h2222);
  endtask

  task automatic t_ones();
    op(0, 16'hFFFF); check(st_r == 0, "R7 status", st_r, 0);
    op(1, 0);        check(rd_r == 16'h2222, "R7 skipped", rd_r, 16'h2222);
    op(0, 16'h3333);
    op(1, 0);        check(rd_r == 16'h3333, "R7 reuse", rd_r, 16'h3333);
  endtask

  task automatic t_fill();
    for (int i = 3; i < 32; i++) op(0, 16'h4000 + 16'(i));
    op(1, 0);        check(rd_r == 16'h401F, "R4 top slot", rd_r, 16'h401F);
    op(0, 16'hABCD); check(st_r == 0, "R5 erase write status", st_r, 0);
    op(1, 0);        check(rd_r == 16'hABCD, "R5 page erased", rd_r, 16'hABCD);
    op(0, 16'h0F0F);
    op(1, 0);        check(rd_r == 16'h0F0F, "R5 slot after erase", rd_r, 16'h0F0F);
  endtask

  task automatic t_busy();
    int pulses = 0;
    @(negedge clk); wr_req = 1; wr_data = 16'h5555;
    @(negedge clk); wr_req = 0;
    check(busy, "R2 busy raised", busy, 1);
    wr_req = 1; rd_req = 1; wr_data = 16'h6666;
    @(negedge clk); wr_req = 0; rd_req = 0;
    wait_done();
    check(st_r == 0, "R2 status", st_r, 0);
    for (int i = 0; i < 4; i++) begin
      if (busy || done) pulses++;
      @(negedge clk);
    end
    check(pulses == 0, "R2 ignored while busy", pulses, 0);
    op(1, 0); check(rd_r == 16'h5555, "R2 ignored data", rd_r, 16'h5555);
    @(negedge clk); init_req = 1; wr_req = 1; rd_req = 1; wr_data = 16'h7777;
    @(negedge clk); init_req = 0; wr_req = 0; rd_req = 0;
    wait_done();
    op(1, 0); check(rd_r == 16'h5555, "R2 init priority", rd_r, 16'h5555);
    check(rd_data == 16'h5555, "R6 rd_data held", rd_data, 16'h5555);
  endtask

  task automatic t_init_keep();
    op(2, 0); check(st_r == 0, "R10 init status", st_r, 0);
    op(1, 0); check(rd_r == 16'h5555, "R10 page kept", rd_r, 16'h5555);
  endtask

  task automatic t_errors();
    for (int i = 3; i < 32; i++) op(0, 16'h0100 + 16'(i));
    stuck = 16'h0001;
    op(0, 16'h2468); check(st_r == 2'd2, "R9 erase error", st_r, 2);
    stuck = 16'h0000;
    op(1, 0); check(rd_r == 16'hFFFE, "R11 erase stuck", rd_r, 16'hFFFE);
    op(0, 16'h1357); check(st_r == 0, "R5 recover", st_r, 0);
    stuck = 16'h0001;
    op(0, 16'h1235); check(st_r == 2'd3, "R8 verify error", st_r, 3);
    stuck = 16'h0000;
    op(1, 0); check(rd_r == 16'h1234, "R11 program stuck", rd_r, 16'h1234);
  endtask

  task automatic t_init_empty();
    do_reset();
    stuck = 16'h8000;
    op(2, 0); check(st_r == 2'd2, "R10 init erases empty", st_r, 2);
    stuck = 16'h0000;
    do_reset();
    op(2, 0); check(st_r == 0, "R10 init ok", st_r, 0);
    op(0, 16'hC0DE);
    op(1, 0); check(rd_r == 16'hC0DE, "R10 usable", rd_r, 16'hC0DE);
  endtask

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_append();
    t_ones();
    t_fill();
    t_busy();
    t_init_keep();
    t_errors();
    t_init_empty();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule